// File: doc/BRIEF.md
# Conditional Jump Evaluation Unit

This unit resolves a jump-class instruction in a processor that keeps no flag register. It takes the instruction's three control bits (link, negate, zero-or-odd select), a target queue number, the value of the register under test, an optional immediate and the address of the following instruction. It then decides whether the jump is taken. The tested value is first combined by exclusive-OR with the sign-extended immediate, or with zero when no immediate is present. The result is then checked either for being all zero or for having its least significant bit set. The negate bit inverts the outcome. The link bit is independent of the condition: it only asks for the next instruction address to be saved when the jump is taken.

A taken jump moves the current-queue pointer, which the unit holds, to the queue named in the instruction. If the jump would land in the middle of a long instruction, the unit raises a trap and does not perform the switch or the link write. The decision is formed combinationally and all outputs are registered, so results appear one clock after the instruction is presented with its valid strobe.

Top module: `jmp_eval_unit`

## Requirements
- R1: The control bits are decoded as {link, negate, odd-select}: 000 jump-if-zero, 001 jump-if-odd, 010 jump-if-nonzero, 011 jump-if-even, and 1xx the same four conditions with linking.
- R2: The tested value is exclusive-ORed with the immediate sign-extended to the data width (bit IMM_W-1 replicated) when `imm_present_i` is 1, and with zero when it is 0.
- R3: When odd-select is 0 and negate is 0, the jump is taken exactly when the exclusive-OR result is all zero.
- R4: When odd-select is 1 and negate is 0, the jump is taken exactly when bit 0 of the exclusive-OR result is 1.
- R5: Setting negate inverts the condition in both modes.
- R6: A taken, non-trapping jump with the link bit set asserts `link_we_o`, places `dst_reg_i` on `link_reg_o` and `next_ip_i` on `link_val_o`.
- R7: A jump that is not taken produces no link write and leaves `cur_queue_o` unchanged.
- R8: A taken, non-trapping jump loads `cur_queue_o` with `tgt_queue_i`.
- R9: A taken jump with `tgt_long_i` = 1 and `tgt_ip_b1_i` = 1 raises `trap_o`. The queue does not change and no link write occurs. No trap is raised if either bit is 0 or if the jump is not taken.
- R10: Outputs are registered: they reflect the instruction presented at the previous rising edge. A cycle with `jmp_valid_i` = 0 gives `taken_o`, `link_we_o` and `trap_o` all 0 and holds the queue.
- R11: After reset, `taken_o`, `link_we_o` and `trap_o` are 0 and `cur_queue_o` equals the parameter RST_QUEUE (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| jmp_valid_i | input | 1 | A jump instruction is presented this cycle |
| ctl_link_i | input | 1 | Link bit |
| ctl_neg_i | input | 1 | Condition negate bit |
| ctl_odd_i | input | 1 | 0: zero test, 1: odd test |
| tgt_queue_i | input | QSEL_W | Queue to switch to when taken |
| dst_reg_i | input | RIDX_W | Register index receiving the link value |
| test_val_i | input | DATA_W | Value of the tested register |
| imm_present_i | input | 1 | An immediate accompanies the instruction |
| imm_i | input | IMM_W | Immediate field |
| next_ip_i | input | DATA_W | Address of the following instruction |
| tgt_long_i | input | 1 | Top bit of the instruction at the target |
| tgt_ip_b1_i | input | 1 | Bit 1 of the target instruction pointer |
| taken_o | output | 1 | Jump taken |
| cur_queue_o | output | QSEL_W | Current queue |
| link_we_o | output | 1 | Link write enable |
| link_reg_o | output | RIDX_W | Link destination register index |
| link_val_o | output | DATA_W | Link value |
| trap_o | output | 1 | Misaligned landing trap |

## Verification
The bench builds the unit with its defaults: a 32-bit data path, a 16-bit immediate, a 2-bit queue number and the landing trap enabled. Because the immediate is half the data width, a value such as 0xFFFF8000 tested against immediate 0x8000 exposes whether sign extension really fills the upper half. Running the same low bits against 0x00008000 shows the opposite outcome. The 2-bit queue lets the bench step through several distinct queues and see a switch, a hold on a not-taken jump and a hold on a trapping jump.

// File: rtl/jmp_eval_pkg.sv
package jmp_eval_pkg;

   typedef struct packed {
      logic link;
      logic neg;
      logic odd;
   } jmp_ctl_t;

   localparam int unsigned JMP_CTL_W = $bits(jmp_ctl_t);

endpackage

// File: rtl/jmp_cond_eval.sv
module jmp_cond_eval
   import jmp_eval_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 16
) (
   input  jmp_ctl_t            ctl,
   input  logic [DATA_W-1:0]   test_val,
   input  logic                imm_present,
   input  logic [IMM_W-1:0]    imm,
   output logic                cond_met
);

   localparam int unsigned EXT_W = (DATA_W > IMM_W) ? (DATA_W - IMM_W) : 1;

   logic [DATA_W-1:0] imm_ext;
   logic [DATA_W-1:0] operand;
   logic [DATA_W-1:0] mixed;
   logic              is_zero;
   logic              raw_cond;

   generate
      if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
         $error("jmp_cond_eval: IMM_W must lie in 1..DATA_W");
      end
      if (IMM_W == DATA_W) begin : g_no_ext
         assign imm_ext = imm;
      end else begin : g_sign_ext
         logic [EXT_W-1:0] fill;
         assign fill    = {EXT_W{imm[IMM_W-1]}};
         assign imm_ext = {fill, imm};
      end
   endgenerate

   always_comb begin
      operand  = imm_present ? imm_ext : '0;
      mixed    = test_val ^ operand;
      is_zero  = (mixed == '0);
      raw_cond = ctl.odd ? mixed[0] : is_zero;
      cond_met = raw_cond ^ ctl.neg;
   end

endmodule

// File: rtl/jmp_land_check.sv
module jmp_land_check #(
   parameter bit ALIGN_TRAP_EN = 1'b1
) (
   input  logic taken,
   input  logic tgt_long,
   input  logic tgt_ip_b1,
   output logic trap
);

   generate
      if (ALIGN_TRAP_EN) begin : g_trap_on
         assign trap = taken & tgt_long & tgt_ip_b1;
      end else begin : g_trap_off
         logic unused_in;
         assign unused_in = taken ^ tgt_long ^ tgt_ip_b1;
         assign trap      = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/jmp_result_reg.sv
module jmp_result_reg #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned QSEL_W    = 2,
   parameter int unsigned RIDX_W    = 4,
   parameter int unsigned RST_QUEUE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              cond_met,
   input  logic              trap_req,
   input  logic              link_bit,
   input  logic [QSEL_W-1:0] tgt_queue,
   input  logic [RIDX_W-1:0] dst_reg,
   input  logic [DATA_W-1:0] next_ip,
   output logic              taken_q,
   output logic [QSEL_W-1:0] cur_queue_q,
   output logic              link_we_q,
   output logic [RIDX_W-1:0] link_reg_q,
   output logic [DATA_W-1:0] link_val_q,
   output logic              trap_q
);

   localparam logic [QSEL_W-1:0] Q_INIT = QSEL_W'(RST_QUEUE);

   generate
      if (QSEL_W < 1 || RST_QUEUE >= (1 << QSEL_W)) begin : g_bad_q
         $error("jmp_result_reg: RST_QUEUE does not fit in QSEL_W bits");
      end
   endgenerate

   logic take_now;
   logic commit;

   always_comb begin
      take_now = valid & cond_met;
      commit   = take_now & ~trap_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken_q     <= 1'b0;
         cur_queue_q <= Q_INIT;
         link_we_q   <= 1'b0;
         link_reg_q  <= '0;
         link_val_q  <= '0;
         trap_q      <= 1'b0;
      end else begin
         taken_q   <= take_now;
         trap_q    <= take_now & trap_req;
         link_we_q <= commit & link_bit;
         if (commit) begin
            cur_queue_q <= tgt_queue;
         end
         if (commit & link_bit) begin
            link_reg_q <= dst_reg;
            link_val_q <= next_ip;
         end
      end
   end

   // R7: a link write only accompanies a taken jump
   assert_link_needs_taken_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      link_we_q |-> taken_q);

   // R7: queue holds across a jump that is not taken
   assert_queue_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !(valid && cond_met) |=> $stable(cur_queue_q));

   // R8: committed jump moves the queue to the requested target
   assert_queue_switch_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid && cond_met && !trap_req) |=> (cur_queue_q == $past(tgt_queue)));

   // R9: a trap never coincides with a link write
   assert_trap_no_link_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      trap_q |-> !link_we_q);

   // R6: the written link value is the address presented with the jump
   assert_link_value_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid && cond_met && !trap_req && link_bit) |=> (link_we_q && link_val_q == $past(next_ip)));

endmodule

// File: rtl/jmp_eval_unit.sv
module jmp_eval_unit
   import jmp_eval_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned IMM_W         = 16,
   parameter int unsigned QSEL_W        = 2,
   parameter int unsigned RIDX_W        = 4,
   parameter int unsigned RST_QUEUE     = 0,
   parameter bit          ALIGN_TRAP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              jmp_valid_i,
   input  logic              ctl_link_i,
   input  logic              ctl_neg_i,
   input  logic              ctl_odd_i,
   input  logic [QSEL_W-1:0] tgt_queue_i,
   input  logic [RIDX_W-1:0] dst_reg_i,
   input  logic [DATA_W-1:0] test_val_i,
   input  logic              imm_present_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [DATA_W-1:0] next_ip_i,
   input  logic              tgt_long_i,
   input  logic              tgt_ip_b1_i,
   output logic              taken_o,
   output logic [QSEL_W-1:0] cur_queue_o,
   output logic              link_we_o,
   output logic [RIDX_W-1:0] link_reg_o,
   output logic [DATA_W-1:0] link_val_o,
   output logic              trap_o
);

   jmp_ctl_t ctl;
   logic     cond_met;
   logic     trap_req;

   assign ctl = '{link: ctl_link_i, neg: ctl_neg_i, odd: ctl_odd_i};

   jmp_cond_eval #(
      .DATA_W (DATA_W),
      .IMM_W  (IMM_W)
   ) u_cond (
      .ctl         (ctl),
      .test_val    (test_val_i),
      .imm_present (imm_present_i),
      .imm         (imm_i),
      .cond_met    (cond_met)
   );

   jmp_land_check #(
      .ALIGN_TRAP_EN (ALIGN_TRAP_EN)
   ) u_land (
      .taken     (cond_met),
      .tgt_long  (tgt_long_i),
      .tgt_ip_b1 (tgt_ip_b1_i),
      .trap      (trap_req)
   );

   jmp_result_reg #(
      .DATA_W    (DATA_W),
      .QSEL_W    (QSEL_W),
      .RIDX_W    (RIDX_W),
      .RST_QUEUE (RST_QUEUE)
   ) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid       (jmp_valid_i),
      .cond_met    (cond_met),
      .trap_req    (trap_req),
      .link_bit    (ctl.link),
      .tgt_queue   (tgt_queue_i),
      .dst_reg     (dst_reg_i),
      .next_ip     (next_ip_i),
      .taken_q     (taken_o),
      .cur_queue_q (cur_queue_o),
      .link_we_q   (link_we_o),
      .link_reg_q  (link_reg_o),
      .link_val_q  (link_val_o),
      .trap_q      (trap_o)
   );

   // R10: an idle cycle yields no outcome on the next cycle
   assert_idle_quiet_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !jmp_valid_i |=> (!taken_o && !link_we_o && !trap_o));

endmodule

// File: tb/tb_jmp_eval_unit.sv
module tb_jmp_eval_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        jmp_valid_i = 1'b0;
   logic        ctl_link_i = 1'b0, ctl_neg_i = 1'b0, ctl_odd_i = 1'b0;
   logic [1:0]  tgt_queue_i = '0;
   logic [3:0]  dst_reg_i = '0;
   logic [31:0] test_val_i = '0;
   logic        imm_present_i = 1'b0;
   logic [15:0] imm_i = '0;
   logic [31:0] next_ip_i = '0;
   logic        tgt_long_i = 1'b0, tgt_ip_b1_i = 1'b0;
   logic        taken_o, link_we_o, trap_o;
   logic [1:0]  cur_queue_o;
   logic [3:0]  link_reg_o;
   logic [31:0] link_val_o;

   int n_vec  = 0;
   int n_miss = 0;
   bit done   = 1'b0;
   logic [1:0] exp_q = 2'd0;

   always #4 clk = ~clk;

   jmp_eval_unit dut (
      .clk(clk), .rst_n(rst_n), .jmp_valid_i(jmp_valid_i),
      .ctl_link_i(ctl_link_i), .ctl_neg_i(ctl_neg_i), .ctl_odd_i(ctl_odd_i),
      .tgt_queue_i(tgt_queue_i), .dst_reg_i(dst_reg_i), .test_val_i(test_val_i),
      .imm_present_i(imm_present_i), .imm_i(imm_i), .next_ip_i(next_ip_i),
      .tgt_long_i(tgt_long_i), .tgt_ip_b1_i(tgt_ip_b1_i),
      .taken_o(taken_o), .cur_queue_o(cur_queue_o), .link_we_o(link_we_o),
      .link_reg_o(link_reg_o), .link_val_o(link_val_o), .trap_o(trap_o)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_miss++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // apply one jump, predict from requirement text, check one cycle later
   task automatic jump(string req, bit v, logic [2:0] code, logic [31:0] val,
                       bit ip, logic [15:0] imm, logic [1:0] q, logic [3:0] dst,
                       logic [31:0] nip, bit lng, bit b1);
      logic [31:0] ext, x;
      bit c, tk, tr, lw;
      @(negedge clk);
      jmp_valid_i = v;
      {ctl_link_i, ctl_neg_i, ctl_odd_i} = code;
      test_val_i = val; imm_present_i = ip; imm_i = imm;
      tgt_queue_i = q; dst_reg_i = dst; next_ip_i = nip;
      tgt_long_i = lng; tgt_ip_b1_i = b1;
      ext = {{16{imm[15]}}, imm};
      x   = val ^ (ip ? ext : 32'd0);
      c   = code[0] ? x[0] : (x == 32'd0);
      c   = c ^ code[1];
      tk  = v & c;
      tr  = tk & lng & b1;
      lw  = tk & ~tr & code[2];
      if (tk && !tr) exp_q = q;
      @(negedge clk);
      jmp_valid_i = 1'b0;
      chk(req, "taken", 32'(taken_o), 32'(tk));
      chk(req, "trap", 32'(trap_o), 32'(tr));
      chk(req, "link_we", 32'(link_we_o), 32'(lw));
      chk(req, "queue", 32'(cur_queue_o), 32'(exp_q));
      if (lw) begin
         chk(req, "link_reg", 32'(link_reg_o), 32'(dst));
         chk(req, "link_val", link_val_o, nip);
      end
   endtask

   task automatic t_reset();
      chk("R11", "taken", 32'(taken_o), 0);
      chk("R11", "link_we", 32'(link_we_o), 0);
      chk("R11", "trap", 32'(trap_o), 0);
      chk("R11", "queue", 32'(cur_queue_o), 0);
   endtask

   task automatic t_zero_odd();
      jump("R3", 1, 3'b000, 32'h0, 0, 16'h0, 2'd1, 4'd0, 32'h0, 0, 0);
      jump("R3", 1, 3'b000, 32'h5, 0, 16'h0, 2'd3, 4'd0, 32'h0, 0, 0);
      jump("R4", 1, 3'b001, 32'h7, 0, 16'h0, 2'd2, 4'd0, 32'h0, 0, 0);
      jump("R4", 1, 3'b001, 32'h6, 0, 16'h0, 2'd0, 4'd0, 32'h0, 0, 0);
   endtask

   task automatic t_negate();
      jump("R5", 1, 3'b010, 32'h0, 0, 16'h0, 2'd3, 4'd0, 32'h0, 0, 0);
      jump("R5", 1, 3'b010, 32'h3, 0, 16'h0, 2'd3, 4'd0, 32'h0, 0, 0);
      jump("R5", 1, 3'b011, 32'h6, 0, 16'h0, 2'd1, 4'd0, 32'h0, 0, 0);
      jump("R1", 1, 3'b011, 32'h7, 0, 16'h0, 2'd2, 4'd0, 32'h0, 0, 0);
   endtask

   task automatic t_immediate();
      jump("R2", 1, 3'b000, 32'hFFFF_8000, 1, 16'h8000, 2'd2, 4'd0, 32'h0, 0, 0);
      jump("R2", 1, 3'b000, 32'h0000_8000, 1, 16'h8000, 2'd0, 4'd0, 32'h0, 0, 0);
      jump("R2", 1, 3'b000, 32'h0000_1234, 0, 16'h1234, 2'd1, 4'd0, 32'h0, 0, 0);
      jump("R2", 1, 3'b001, 32'h2, 1, 16'h1, 2'd0, 4'd0, 32'h0, 0, 0);
   endtask

   task automatic t_link();
      jump("R6", 1, 3'b100, 32'h0, 0, 16'h0, 2'd1, 4'd11, 32'h0000_1234, 0, 0);
      jump("R6", 1, 3'b111, 32'h8, 0, 16'h0, 2'd3, 4'd9, 32'hCAFE_0004, 0, 0);
      jump("R7", 1, 3'b110, 32'h0, 0, 16'h0, 2'd2, 4'd5, 32'h0000_0040, 0, 0);
      jump("R1", 1, 3'b101, 32'h1, 0, 16'h0, 2'd2, 4'd7, 32'h0000_0080, 0, 0);
   endtask

   task automatic t_queue();
      jump("R8", 1, 3'b000, 32'h0, 0, 16'h0, 2'd2, 4'd0, 32'h0, 0, 0);
      jump("R7", 1, 3'b000, 32'h1, 0, 16'h0, 2'd3, 4'd0, 32'h0, 0, 0);
   endtask

   task automatic t_trap();
      jump("R9", 1, 3'b100, 32'h0, 0, 16'h0, 2'd1, 4'd3, 32'h100, 1, 1);
      jump("R9", 1, 3'b000, 32'h0, 0, 16'h0, 2'd0, 4'd0, 32'h0, 1, 0);
      jump("R9", 1, 3'b000, 32'h0, 0, 16'h0, 2'd1, 4'd0, 32'h0, 0, 1);
      jump("R9", 1, 3'b000, 32'h9, 0, 16'h0, 2'd3, 4'd0, 32'h0, 1, 1);
   endtask

   task automatic t_idle();
      jump("R10", 0, 3'b100, 32'h0, 0, 16'h0, 2'd3, 4'd2, 32'h44, 0, 0);
      jump("R10", 0, 3'b000, 32'h0, 0, 16'h0, 2'd2, 4'd0, 32'h0, 1, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_zero_odd();
      t_negate();
      t_immediate();
      t_link();
      t_queue();
      t_trap();
      t_idle();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_vec++;
         n_miss++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
         $finish;
      end
   end

endmodule